// File: doc/BRIEF.md
# Synchronized Snapshot Trigger Sequencer

This block turns a decoded "synchronize" command on a single-wire serial bus into one timed measurement capture. An arm pulse from the command decoder readies the block. The block then watches the bus line for the first data bit. A data bit is a low excursion from the idle-high line, and the capture triggers on the moment the line returns high. A bus reset that comes before that bit cancels the request and leaves no trace.

After a trigger the block counts clock cycles. It gives a current-sample strobe one sample period later, then a voltage-sample strobe a fixed offset after that, and then returns to idle. A sticky status flag records that a capture took place. The flag is set by the block alone, and only a host write of zero clears it.

Both times are parameters counted in clock cycles. With the default values at 100 MHz the sample period is about 687 us and the offset is about 343 us, roughly half a period.

Top module: `snap_trigger_seq`

## Requirements
- R1: While reset is held and just after it is released, curStrobe, voltStrobe and snapFlag are all 0.
- R2: After an arm pulse, a rising edge on busLine is seen through a two-stage synchronizer. If busLine goes high just before clock edge k, the trigger takes place at edge k+2 and snapFlag reads 1 after that edge and not before it.
- R3: If the trigger takes place at edge T, curStrobe is high for exactly one cycle, the one after edge T+PERIOD_CYC. voltStrobe is high for exactly one cycle, the one after edge T+PERIOD_CYC+OFFSET_CYC. The two strobes are never high together.
- R4: Once a capture has triggered, any further rising edges on busLine, such as the remaining bits of a byte, produce no more strobes.
- R5: A bus-reset pulse while the block is armed, including one in the same cycle as the first rising edge, cancels the capture. No strobe follows and snapFlag stays 0. A bus-reset pulse during a running strobe sequence has no effect.
- R6: A rising edge on busLine with no preceding arm produces no strobe and does not set snapFlag.
- R7: An arm pulse while the block is already armed or running is ignored, and a running sequence still delivers both of its strobes exactly once.
- R8: snapFlag clears only in the cycle after a host write (flagWrEn=1) with flagWrData=0. A write with flagWrData=1 leaves it unchanged.
- R9: When a trigger and a host clear write fall in the same cycle, the set wins and snapFlag reads 1.
- R10: An arm, then a bus reset, then a new arm, then a first-bit rising edge gives a normal capture.
- R11: After the voltage strobe the block is idle again, and a new arm followed by a first bit gives a full new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armPulse | input | 1 | One-cycle pulse from the command decoder for the sync command |
| busLine | input | 1 | Raw serial bus line level (asynchronous, idles high) |
| busResetPulse | input | 1 | One-cycle pulse when a bus reset is detected |
| flagWrEn | input | 1 | Host write strobe for the status flag |
| flagWrData | input | 1 | Host write value for the status flag (0 clears) |
| curStrobe | output | 1 | One-cycle current-sample strobe |
| voltStrobe | output | 1 | One-cycle voltage-sample strobe |
| snapFlag | output | 1 | Sticky capture-done flag |

## Verification
The internal set of snapFlag and the host clear write can land in the same cycle. The bench provokes this by timing a zero write so that it is registered on the exact edge at which the synchronized rising edge triggers. It expects snapFlag to read 1 afterwards, and a separate zero write on a later cycle must then clear it. A scoreboard of expected strobe cycles, built from the edge timing in the requirements, judges every strobe the design gives.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } snapState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic trig;   // trigger edge accepted: clear counter, set flag
    logic cntEn;  // sequence running: advance counter, decode strobes
  } snapCtl_t;

endpackage

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     armPulse,
  input  logic     busResetPulse,
  input  logic     lineRise,
  input  logic     seqDone,
  output snapCtl_t ctl
);

  snapState_t state;
  snapState_t stateNxt;

  always_comb begin
    stateNxt  = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (armPulse) stateNxt = ST_ARMED;
      end
      ST_ARMED: begin
        // a bus reset aborts even if the edge arrives in the same cycle
        if (busResetPulse) begin
          stateNxt = ST_IDLE;
        end else if (lineRise) begin
          ctl.trig = 1'b1;
          stateNxt = ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.cntEn = 1'b1;
        if (seqDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/snap_datapath.sv
module snap_datapath
  import snap_pkg::*;
#(
  parameter int PERIOD_CYC  = 68750,
  parameter int OFFSET_CYC  = 34375,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busLine,
  input  logic     flagWrEn,
  input  logic     flagWrData,
  input  snapCtl_t ctl,
  output logic     lineRise,
  output logic     curStrobe,
  output logic     voltStrobe,
  output logic     snapFlag
);

  localparam int LAST_CYC = PERIOD_CYC + OFFSET_CYC;
  localparam int CNT_W    = $clog2(LAST_CYC + 1);
  localparam logic [CNT_W-1:0] CUR_AT  = CNT_W'(PERIOD_CYC);
  localparam logic [CNT_W-1:0] VOLT_AT = CNT_W'(LAST_CYC);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   lineSync;
  logic                   linePrev;
  logic [CNT_W-1:0]       cnt;

  // synchronizer, reset to the idle-high bus level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= busLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], busLine};
      end
    end
  endgenerate

  assign lineSync = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) linePrev <= 1'b1;
    else       linePrev <= lineSync;
  end

  assign lineRise = lineSync & ~linePrev;

  // sequence counter
  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.trig)  cnt <= '0;
    else if (ctl.cntEn) cnt <= cnt + 1'b1;
  end

  assign curStrobe  = ctl.cntEn && (cnt == CUR_AT);
  assign voltStrobe = ctl.cntEn && (cnt == VOLT_AT);

  // sticky flag: internal set takes precedence over host clear
  always_ff @(posedge clk) begin
    if (!rstN)                       snapFlag <= 1'b0;
    else if (ctl.trig)               snapFlag <= 1'b1;
    else if (flagWrEn && !flagWrData) snapFlag <= 1'b0;
  end

endmodule

// File: rtl/snap_trigger_seq.sv
module snap_trigger_seq
  import snap_pkg::*;
#(
  parameter int PERIOD_CYC = 68750,
  parameter int OFFSET_CYC = 34375
) (
  input  logic clk,
  input  logic rstN,
  input  logic armPulse,
  input  logic busLine,
  input  logic busResetPulse,
  input  logic flagWrEn,
  input  logic flagWrData,
  output logic curStrobe,
  output logic voltStrobe,
  output logic snapFlag
);

  snapCtl_t ctlBus;
  logic     lineRise;
  logic     trigEvt;

  snap_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .armPulse      (armPulse),
    .busResetPulse (busResetPulse),
    .lineRise      (lineRise),
    .seqDone       (voltStrobe),
    .ctl           (ctlBus)
  );

  snap_datapath #(
    .PERIOD_CYC  (PERIOD_CYC),
    .OFFSET_CYC  (OFFSET_CYC),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busLine    (busLine),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .ctl        (ctlBus),
    .lineRise   (lineRise),
    .curStrobe  (curStrobe),
    .voltStrobe (voltStrobe),
    .snapFlag   (snapFlag)
  );

  assign trigEvt = ctlBus.trig;

endmodule

// File: rtl/snap_trigger_chk.sv
module snap_trigger_chk (
  input logic clk,
  input logic rstN,
  input logic flagWrEn,
  input logic flagWrData,
  input logic trigEvt,
  input logic curStrobe,
  input logic voltStrobe,
  input logic snapFlag
);

  a_r3_cur_single: assert property (@(posedge clk) disable iff (!rstN)
    curStrobe |=> !curStrobe);

  a_r3_volt_single: assert property (@(posedge clk) disable iff (!rstN)
    voltStrobe |=> !voltStrobe);

  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (!rstN)
    curStrobe |-> !voltStrobe);

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (snapFlag && !(flagWrEn && !flagWrData)) |=> snapFlag);

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !flagWrData && !trigEvt) |=> !snapFlag);

  a_r2_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(snapFlag) |-> $past(trigEvt));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    trigEvt |=> snapFlag);

endmodule

bind snap_trigger_seq snap_trigger_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flagWrEn   (flagWrEn),
  .flagWrData (flagWrData),
  .trigEvt    (trigEvt),
  .curStrobe  (curStrobe),
  .voltStrobe (voltStrobe),
  .snapFlag   (snapFlag)
);

// File: tb/tb_snap_trigger_seq.sv
`timescale 1ns/1ps
module tb_snap_trigger_seq;

  localparam int P = 8;
  localparam int O = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armPulse = 1'b0;
  logic busLine = 1'b1;
  logic busResetPulse = 1'b0;
  logic flagWrEn = 1'b0;
  logic flagWrData = 1'b1;
  logic curStrobe, voltStrobe, snapFlag;

  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  bit done = 0;
  int expKind[$];
  int expCyc[$];

  always #4 clk = ~clk;  // 125 MHz

  snap_trigger_seq #(.PERIOD_CYC(P), .OFFSET_CYC(O)) dut (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .busLine(busLine),
    .busResetPulse(busResetPulse), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .curStrobe(curStrobe), .voltStrobe(voltStrobe), .snapFlag(snapFlag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare each observed strobe against the scoreboard
  task automatic observe(input int kind);
    if (expKind.size() == 0) begin
      check(0, "R4/R6/R7 unexpected strobe kind", kind, -1);
    end else begin
      int k = expKind.pop_front();
      int c = expCyc.pop_front();
      check(k == kind, "R3 strobe order", kind, k);
      check(c == cyc, "R3 strobe cycle", cyc, c);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (curStrobe)  observe(0);
      if (voltStrobe) observe(1);
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); armPulse = 1'b1;
    @(negedge clk); armPulse = 1'b0;
  endtask

  task automatic busReset();
    @(negedge clk); busResetPulse = 1'b1;
    @(negedge clk); busResetPulse = 1'b0;
  endtask

  task automatic hostWrite(input bit v);
    @(negedge clk); flagWrEn = 1'b1; flagWrData = v;
    @(negedge clk); flagWrEn = 1'b0; flagWrData = 1'b1;
  endtask

  // drive a bit low, then raise the line; returns cycle count at the rise
  task automatic sendBit(input bit expectTrig, output int c);
    @(negedge clk); busLine = 1'b0;
    repeat (3) @(negedge clk);
    busLine = 1'b1;
    c = cyc;
    if (expectTrig) begin
      expKind.push_back(0); expCyc.push_back(c + 3 + P);
      expKind.push_back(1); expCyc.push_back(c + 3 + P + O);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    check(expKind.size() == 0, "R3 missing strobes", expKind.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      finishRun();
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check(!curStrobe && !voltStrobe && !snapFlag, "R1 during reset",
          {curStrobe, voltStrobe, snapFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!curStrobe && !voltStrobe && !snapFlag, "R1 after reset",
          {curStrobe, voltStrobe, snapFlag}, 0);

    // R2 + R3 + R4: basic capture, rest of a byte ignored
    arm();
    idle(2);
    sendBit(1, c);
    waitCyc(c + 2);
    check(snapFlag == 0, "R2 flag not early", snapFlag, 0);
    waitCyc(c + 3);
    check(snapFlag == 1, "R2 flag set after trigger", snapFlag, 1);
    for (int i = 0; i < 3; i++) begin
      int d;
      sendBit(0, d);  // R4 later bits
    end
    idle(20);

    // R8: write 1 no effect, write 0 clears
    hostWrite(1'b1);
    check(snapFlag == 1, "R8 write one keeps flag", snapFlag, 1);
    hostWrite(1'b0);
    check(snapFlag == 0, "R8 write zero clears", snapFlag, 0);

    // R6: edge without arm
    sendBit(0, c);
    idle(P + O + 6);
    check(snapFlag == 0, "R6 no arm no flag", snapFlag, 0);

    // R5: reset while armed aborts
    arm();
    busReset();
    sendBit(0, c);
    idle(P + O + 6);
    check(snapFlag == 0, "R5 abort keeps flag clear", snapFlag, 0);

    // R5: reset in same cycle as first edge
    arm();
    sendBit(0, c);
    waitCyc(c + 2);
    busResetPulse = 1'b1;
    @(negedge clk); busResetPulse = 1'b0;
    idle(P + O + 6);
    check(snapFlag == 0, "R5 simultaneous reset aborts", snapFlag, 0);

    // R10: arm, reset, arm, trigger
    arm();
    busReset();
    arm();
    sendBit(1, c);
    waitCyc(c + 3);
    check(snapFlag == 1, "R10 re-arm triggers", snapFlag, 1);
    // R7 + R5: arm, reset and edges while running are ignored
    arm();
    busReset();
    begin
      int d;
      sendBit(0, d);
    end
    arm();
    idle(P + O + 6);
    check(expKind.size() == 0, "R7 run completed", expKind.size(), 0);

    // R7: arm while armed is ignored
    hostWrite(1'b0);
    arm();
    arm();
    sendBit(1, c);
    idle(P + O + 6);
    check(snapFlag == 1, "R7 double arm single capture", snapFlag, 1);

    // R11: idle after voltage strobe, new capture works
    hostWrite(1'b0);
    check(snapFlag == 0, "R11 flag cleared", snapFlag, 0);
    arm();
    sendBit(1, c);
    waitCyc(c + 3);
    check(snapFlag == 1, "R11 new capture", snapFlag, 1);
    idle(P + O + 6);

    // R9: clear write registered on the trigger edge
    hostWrite(1'b0);
    arm();
    sendBit(1, c);
    waitCyc(c + 2);
    flagWrEn = 1'b1; flagWrData = 1'b0;
    @(negedge clk);
    flagWrEn = 1'b0; flagWrData = 1'b1;
    check(snapFlag == 1, "R9 set wins over clear", snapFlag, 1);
    idle(P + O + 6);
    hostWrite(1'b0);
    check(snapFlag == 0, "R9 later clear works", snapFlag, 0);

    finishRun();
  end

endmodule